// File: doc/BRIEF.md
# Battery Gauge Two-Wire Slave with Reduced Command Set

This block is the bus-side target of a battery fuel gauge on an SMBus link. It recognises one fixed 7-bit slave address, takes a command byte, and then serves exactly three transaction shapes. The first is a 16-bit word read of a telemetry value or the cut-off threshold. The second is a 16-bit word write of the cut-off threshold. The third is a block read that returns a byte count followed by an identification string. Anything else is refused with a NACK. The gauge algorithm supplies the six telemetry words as a flat input bus. The cut-off threshold lives in a register inside the block and is presented on an output for the algorithm to use.

SCL and SDA are sampled by the system clock through a synchroniser. The slave only ever pulls SDA low, and it never holds SCL. The pad is modelled as an input, an output enable and a constant drive value of zero. The identification strings are computed from a parameter, not stored, so no memory is needed for them.

Top module: `smb_gauge_slave`

## Requirements
- R1: Only the address `SLAVE_ADDR` (default 0x0B) is acknowledged. Any other address byte gets no ACK, and SDA stays released for the rest of that transaction.
- R2: A Read Word (write address, command, repeated START, read address, two data bytes) returns the low byte first and then the high byte. Command codes map as follows: 0x08 to `tel_words[15:0]`, 0x09 to `[31:16]`, 0x0A to `[47:32]`, 0x0B to `[63:48]`, 0x0F to `[79:64]`, 0x10 to `[95:80]`, and 0x3F to the cut-off register.
- R3: A Read Block returns a count byte and then the payload in ascending order. Byte k (k = 0 first) of string p equals `ID_BASE + 16*p + k`. The strings are: p=0 on command 0x20 with 12 bytes, p=1 on 0x21 with 8 bytes, p=2 on 0x22 with 6 bytes, p=3 on 0x23 with 6 bytes, and p=4 on 0x3C with 5 bytes.
- R4: A command byte whose code is not in the R2 or R3 map is NACKed.
- R5: A Write Word to 0x3F acknowledges both data bytes, the low byte arriving first. `cutoff_o` takes the new value only after the second data byte has been acknowledged, and a later Read Word of 0x3F returns it.
- R6: A Write Word to any other listed command has its first data byte NACKed, and `cutoff_o` stays unchanged.
- R7: When the master NACKs a byte of a read, the slave stops driving SDA and keeps it released until the next START.
- R8: A STOP at any point returns the slave to idle with SDA released. A Write Word cut off by a STOP after only one data byte leaves `cutoff_o` unchanged.
- R9: After reset `sda_oe` is 0 and `cutoff_o` equals `CUTOFF_RST`.
- R10: A read-direction address that follows a STOP, with no command byte received since, is NACKed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL level seen at the pad |
| sda_i | input | 1 | SDA level seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA to the drive value |
| sda_do | output | 1 | SDA drive value, constant 0 |
| tel_words | input | 96 | Six 16-bit telemetry words from the gauge algorithm |
| cutoff_o | output | 16 | Cut-off voltage threshold register |

## Verification
A wrong internal state in this block shows up on the wire within one byte time. It appears as a missing or extra ACK in the ninth bit slot, or as a wrong bit driven on the next SCL low phase. It can also appear as SDA held low after a NACK or STOP, which the master sees in the next clock cycle after its SCL edge passes the synchroniser. A bad threshold commit only shows when `cutoff_o` or a later Read Word of 0x3F is examined, so every write is followed by a readback.

// File: rtl/smbg_pkg.sv
package smbg_pkg;

   localparam int unsigned N_TEL  = 6;
   localparam int unsigned WORD_W = 16;

   typedef enum logic [1:0] {K_NONE, K_WORD, K_BLOCK} kind_e;

   typedef enum logic [2:0] {
      ST_IDLE, ST_RX, ST_RX_ACK, ST_TX, ST_TX_ACK, ST_TX_GO
   } bus_st_e;

   typedef enum logic [1:0] {G_ADDR, G_CMD, G_WDATA, G_READ} stage_e;

   typedef struct packed {
      kind_e      kind;
      logic       wr_ok;
      logic [2:0] slot;   // word slot 0..5, 6 = cut-off; or string index 0..4
      logic [3:0] len;    // payload length of a string
   } cmd_info_t;

   function automatic cmd_info_t decode_cmd(input logic [7:0] c);
      cmd_info_t r;
      r = '{kind: K_NONE, wr_ok: 1'b0, slot: 3'd0, len: 4'd0};
      case (c)
         8'h08: r = '{K_WORD,  1'b0, 3'd0, 4'd2};
         8'h09: r = '{K_WORD,  1'b0, 3'd1, 4'd2};
         8'h0A: r = '{K_WORD,  1'b0, 3'd2, 4'd2};
         8'h0B: r = '{K_WORD,  1'b0, 3'd3, 4'd2};
         8'h0F: r = '{K_WORD,  1'b0, 3'd4, 4'd2};
         8'h10: r = '{K_WORD,  1'b0, 3'd5, 4'd2};
         8'h3F: r = '{K_WORD,  1'b1, 3'd6, 4'd2};
         8'h20: r = '{K_BLOCK, 1'b0, 3'd0, 4'd12};
         8'h21: r = '{K_BLOCK, 1'b0, 3'd1, 4'd8};
         8'h22: r = '{K_BLOCK, 1'b0, 3'd2, 4'd6};
         8'h23: r = '{K_BLOCK, 1'b0, 3'd3, 4'd6};
         8'h3C: r = '{K_BLOCK, 1'b0, 3'd4, 4'd5};
         default: ;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/smbg_sync.sv
module smbg_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_s,
   output logic start_ev,
   output logic stop_ev,
   output logic scl_rise,
   output logic scl_fall
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("smbg_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] scl_ff, sda_ff;
   logic              scl_q, sda_q, scl_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_ff <= '1;
         sda_ff <= '1;
         scl_q  <= 1'b1;
         sda_q  <= 1'b1;
      end else begin
         scl_ff <= {scl_ff[STAGES-2:0], scl_i};
         sda_ff <= {sda_ff[STAGES-2:0], sda_i};
         scl_q  <= scl_ff[STAGES-1];
         sda_q  <= sda_ff[STAGES-1];
      end
   end

   assign scl_s    = scl_ff[STAGES-1];
   assign sda_s    = sda_ff[STAGES-1];
   assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;
   assign scl_rise = scl_s & ~scl_q;
   assign scl_fall = ~scl_s & scl_q;

endmodule

// File: rtl/smbg_regfile.sv
module smbg_regfile
   import smbg_pkg::*;
#(
   parameter logic [7:0]        ID_BASE    = 8'h40,
   parameter logic [WORD_W-1:0] CUTOFF_RST = 16'h1770
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [N_TEL*WORD_W-1:0] tel_words,
   input  logic [7:0]              cmd,
   input  logic [4:0]              idx,
   input  logic                    wr_en,
   input  logic [WORD_W-1:0]       wr_data,
   output logic [7:0]              rd_byte,
   output logic [WORD_W-1:0]       cutoff
);

   logic [WORD_W-1:0] tel [N_TEL];
   logic [WORD_W-1:0] word_sel;
   logic [7:0]        str_byte;
   cmd_info_t         info;

   for (genvar g = 0; g < N_TEL; g++) begin : g_unpack
      assign tel[g] = tel_words[g*WORD_W +: WORD_W];
   end

   assign info = decode_cmd(cmd);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cutoff <= CUTOFF_RST;
      else if (wr_en) cutoff <= wr_data;
   end

   always_comb begin
      if (info.slot < 3'(N_TEL)) word_sel = tel[info.slot];
      else                      word_sel = cutoff;
   end

   assign str_byte = ID_BASE + {1'b0, info.slot, 4'b0000} + {3'b000, idx - 5'd1};

   always_comb begin
      rd_byte = 8'hFF;
      case (info.kind)
         K_WORD: begin
            if (idx == 5'd0)      rd_byte = word_sel[7:0];
            else if (idx == 5'd1) rd_byte = word_sel[15:8];
         end
         K_BLOCK: begin
            if (idx == 5'd0)                    rd_byte = {4'h0, info.len};
            else if (idx <= {1'b0, info.len})   rd_byte = str_byte;
         end
         default: ;
      endcase
   end

   // R6: a commit only ever targets the writable parameter
   a_r6_only_writable: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> info.wr_ok);

   // R5: the threshold moves only on a commit pulse
   a_r5_cutoff_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(cutoff));

endmodule

// File: rtl/smbg_engine.sv
module smbg_engine
   import smbg_pkg::*;
#(
   parameter logic [6:0] SLAVE_ADDR = 7'h0B
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sda_s,
   input  logic              start_ev,
   input  logic              stop_ev,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic [7:0]        rd_byte,
   output logic [7:0]        cmd_q,
   output logic [4:0]        byte_idx,
   output logic              wr_en,
   output logic [WORD_W-1:0] wr_data,
   output logic              sda_oe
);

   bus_st_e    st;
   stage_e     stage;
   logic [2:0] bit_cnt;
   logic [7:0] sr, tx_sr, lo_q;
   logic       full, rd_q, cmd_ok, acc;
   cmd_info_t  rx_info, q_info;

   assign rx_info = decode_cmd(sr);
   assign q_info  = decode_cmd(cmd_q);

   always_comb begin
      case (stage)
         G_ADDR:  acc = (sr[7:1] == SLAVE_ADDR) && (!sr[0] || cmd_ok);
         G_CMD:   acc = (rx_info.kind != K_NONE);
         G_WDATA: acc = q_info.wr_ok && (byte_idx < 5'd2);
         default: acc = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= ST_IDLE; stage <= G_ADDR; bit_cnt <= '0; sr <= '0; tx_sr <= '0;
         lo_q <= '0; full <= 1'b0; rd_q <= 1'b0; cmd_ok <= 1'b0; cmd_q <= '0;
         byte_idx <= '0; wr_en <= 1'b0; wr_data <= '0; sda_oe <= 1'b0;
      end else begin
         wr_en <= 1'b0;
         if (stop_ev) begin
            st <= ST_IDLE; sda_oe <= 1'b0; cmd_ok <= 1'b0; full <= 1'b0;
         end else if (start_ev) begin
            st <= ST_RX; stage <= G_ADDR; bit_cnt <= '0; sda_oe <= 1'b0; full <= 1'b0;
         end else begin
            case (st)
               ST_RX: begin
                  if (scl_rise) begin
                     sr      <= {sr[6:0], sda_s};
                     bit_cnt <= bit_cnt + 3'd1;
                     if (bit_cnt == 3'd7) full <= 1'b1;
                  end else if (scl_fall && full) begin
                     full <= 1'b0;
                     if (acc) begin
                        sda_oe <= 1'b1;
                        st     <= ST_RX_ACK;
                        case (stage)
                           G_ADDR:  begin rd_q <= sr[0]; byte_idx <= '0; end
                           G_CMD:   begin cmd_q <= sr; cmd_ok <= 1'b1; end
                           G_WDATA: if (byte_idx == 5'd0) lo_q <= sr;
                           default: ;
                        endcase
                     end else begin
                        st <= ST_IDLE;
                     end
                  end
               end
               ST_RX_ACK: if (scl_fall) begin
                  sda_oe <= 1'b0;
                  st     <= ST_RX;
                  case (stage)
                     G_ADDR: if (rd_q) begin
                        tx_sr   <= rd_byte;
                        sda_oe  <= ~rd_byte[7];
                        bit_cnt <= '0;
                        st      <= ST_TX;
                        stage   <= G_READ;
                     end else begin
                        stage <= G_CMD;
                     end
                     G_CMD: begin stage <= G_WDATA; byte_idx <= '0; end
                     G_WDATA: begin
                        if (byte_idx == 5'd1) begin
                           wr_en   <= 1'b1;
                           wr_data <= {sr, lo_q};
                        end
                        byte_idx <= byte_idx + 5'd1;
                     end
                     default: ;
                  endcase
               end
               ST_TX: if (scl_fall) begin
                  if (bit_cnt == 3'd7) begin
                     sda_oe  <= 1'b0;
                     bit_cnt <= '0;
                     st      <= ST_TX_ACK;
                  end else begin
                     tx_sr   <= {tx_sr[6:0], 1'b1};
                     sda_oe  <= ~tx_sr[6];
                     bit_cnt <= bit_cnt + 3'd1;
                  end
               end
               ST_TX_ACK: if (scl_rise) begin
                  if (sda_s) st <= ST_IDLE;
                  else begin
                     st <= ST_TX_GO;
                     if (byte_idx != 5'h1F) byte_idx <= byte_idx + 5'd1;
                  end
               end
               ST_TX_GO: if (scl_fall) begin
                  tx_sr  <= rd_byte;
                  sda_oe <= ~rd_byte[7];
                  st     <= ST_TX;
               end
               default: ;
            endcase
         end
      end
   end

   // R8: a STOP always leaves SDA released
   a_r8_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
      stop_ev |=> !sda_oe);

   // R1: an idle slave never pulls the line
   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE) |-> !sda_oe);

   // R7: a master NACK on a read ends the transfer with SDA free
   a_r7_nack_release: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_TX_ACK && scl_rise && sda_s && !stop_ev && !start_ev)
         |=> (st == ST_IDLE && !sda_oe));

   // R5: the commit pulse comes only from the data stage of a write
   a_r5_commit_stage: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (stage == G_WDATA && byte_idx == 5'd2));

endmodule

// File: rtl/smb_gauge_slave.sv
module smb_gauge_slave
   import smbg_pkg::*;
#(
   parameter logic [6:0]        SLAVE_ADDR  = 7'h0B,
   parameter int unsigned       SYNC_STAGES = 2,
   parameter logic [7:0]        ID_BASE     = 8'h40,
   parameter logic [WORD_W-1:0] CUTOFF_RST  = 16'h1770
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    scl_i,
   input  logic                    sda_i,
   output logic                    sda_oe,
   output logic                    sda_do,
   input  logic [N_TEL*WORD_W-1:0] tel_words,
   output logic [WORD_W-1:0]       cutoff_o
);

   generate
      if (ID_BASE > 8'hAF) begin : g_bad_base
         $error("smb_gauge_slave: ID_BASE leaves no room for the strings");
      end
   endgenerate

   logic              sda_s, start_ev, stop_ev, scl_rise, scl_fall, wr_en;
   logic [7:0]        cmd_q, rd_byte;
   logic [4:0]        byte_idx;
   logic [WORD_W-1:0] wr_data;

   assign sda_do = 1'b0;

   smbg_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk, .rst_n, .scl_i, .sda_i, .sda_s, .start_ev, .stop_ev, .scl_rise, .scl_fall
   );

   smbg_engine #(.SLAVE_ADDR(SLAVE_ADDR)) u_engine (
      .clk, .rst_n, .sda_s, .start_ev, .stop_ev, .scl_rise, .scl_fall,
      .rd_byte, .cmd_q, .byte_idx, .wr_en, .wr_data, .sda_oe
   );

   smbg_regfile #(.ID_BASE(ID_BASE), .CUTOFF_RST(CUTOFF_RST)) u_regs (
      .clk, .rst_n, .tel_words, .cmd(cmd_q), .idx(byte_idx),
      .wr_en, .wr_data, .rd_byte, .cutoff(cutoff_o)
   );

endmodule

// File: tb/smb_gauge_slave_test.sv
module smb_gauge_slave_test;

   localparam int         HP     = 8;
   localparam logic [7:0] ID_B   = 8'h40;
   localparam logic [15:0] CRST  = 16'h1770;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        scl_m = 1'b1, sda_m = 1'b1;
   logic        sda_oe, sda_do;
   logic [15:0] tel [6];
   logic [95:0] tel_words;
   logic [15:0] cutoff_o;
   logic [15:0] cut_model = CRST;
   wire         sda_bus = sda_m & ~sda_oe;
   int          checks = 0, errors = 0;

   always #4 clk = ~clk;

   always_comb for (int i = 0; i < 6; i++) tel_words[i*16 +: 16] = tel[i];

   smb_gauge_slave #(.ID_BASE(ID_B), .CUTOFF_RST(CRST)) uut (
      .clk, .rst_n, .scl_i(scl_m), .sda_i(sda_bus), .sda_oe, .sda_do,
      .tel_words, .cutoff_o
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic int word_slot(input logic [7:0] c);
      case (c)
         8'h08: return 0; 8'h09: return 1; 8'h0A: return 2;
         8'h0B: return 3; 8'h0F: return 4; 8'h10: return 5;
         8'h3F: return 6;
         default: return -1;
      endcase
   endfunction

   function automatic int str_idx(input logic [7:0] c);
      case (c)
         8'h20: return 0; 8'h21: return 1; 8'h22: return 2;
         8'h23: return 3; 8'h3C: return 4;
         default: return -1;
      endcase
   endfunction

   function automatic int str_len(input int p);
      case (p) 0: return 12; 1: return 8; 2: return 6; 3: return 6; default: return 5; endcase
   endfunction

   function automatic logic [15:0] exp_word(input logic [7:0] c);
      int s = word_slot(c);
      return (s == 6) ? cut_model : tel[s];
   endfunction

   task automatic half();  repeat (HP) @(negedge clk);  endtask

   task automatic m_start();
      sda_m = 1'b1; scl_m = 1'b1; half(); sda_m = 1'b0; half(); scl_m = 1'b0; half();
   endtask

   task automatic m_rstart();
      sda_m = 1'b1; half(); scl_m = 1'b1; half(); sda_m = 1'b0; half(); scl_m = 1'b0; half();
   endtask

   task automatic m_stop();
      sda_m = 1'b0; half(); scl_m = 1'b1; half(); sda_m = 1'b1; half();
   endtask

   task automatic wbyte(input logic [7:0] b, output bit ack);
      for (int i = 7; i >= 0; i--) begin
         sda_m = b[i]; half(); scl_m = 1'b1; half(); scl_m = 1'b0;
      end
      sda_m = 1'b1; half(); scl_m = 1'b1; half(); ack = ~sda_bus; scl_m = 1'b0;
   endtask

   task automatic rbyte(input bit nack, output logic [7:0] b);
      sda_m = 1'b1;
      for (int i = 0; i < 8; i++) begin
         half(); scl_m = 1'b1; half(); b = {b[6:0], sda_bus}; scl_m = 1'b0;
      end
      sda_m = nack; half(); scl_m = 1'b1; half(); scl_m = 1'b0; half(); sda_m = 1'b1;
   endtask

   // command phase then repeated start and read address; returns the ack bits
   task automatic rd_prefix(input logic [7:0] c, output bit [2:0] acks);
      bit a;
      m_start(); wbyte(8'h16, a); acks[0] = a;
      wbyte(c, a); acks[1] = a;
      m_rstart(); wbyte(8'h17, a); acks[2] = a;
   endtask

   task automatic rd_word_chk(input logic [7:0] c);
      bit [2:0] acks; logic [7:0] lo, hi; logic [15:0] e;
      e = exp_word(c);
      rd_prefix(c, acks);
      chk(acks == 3'b111, "R2 read word acks", acks, 7);
      rbyte(1'b0, lo); rbyte(1'b1, hi);
      repeat (6) @(negedge clk);
      chk(!sda_oe, "R7 released after read nack", sda_oe, 0);
      m_stop();
      chk({hi, lo} == e, $sformatf("R2 word cmd %02h", c), {hi, lo}, e);
   endtask

   task automatic rd_block_chk(input logic [7:0] c, input int stop_after);
      bit [2:0] acks; logic [7:0] b; int p, n, lim;
      p = str_idx(c); n = str_len(p);
      lim = (stop_after < n) ? stop_after : n;
      rd_prefix(c, acks);
      chk(acks == 3'b111, "R3 block acks", acks, 7);
      rbyte(lim == 0, b);
      chk(b == 8'(n), $sformatf("R3 count cmd %02h", c), b, n);
      for (int k = 0; k < lim; k++) begin
         rbyte(k == lim - 1, b);
         chk(b == 8'(ID_B + 16*p + k), $sformatf("R3 cmd %02h byte %0d", c, k), b, ID_B + 16*p + k);
      end
      repeat (6) @(negedge clk);
      chk(!sda_oe, "R7 released after block nack", sda_oe, 0);
      m_stop();
   endtask

   task automatic wr_word(input logic [7:0] c, input logic [15:0] v, output bit [3:0] acks);
      bit a;
      acks = '0;
      m_start(); wbyte(8'h16, a); acks[0] = a;
      wbyte(c, a); acks[1] = a;
      wbyte(v[7:0], a); acks[2] = a;
      if (a) begin wbyte(v[15:8], a); acks[3] = a; end
      m_stop();
   endtask

   initial begin
      bit [3:0] wa; bit a; logic [15:0] v; logic [7:0] c;
      logic [7:0] wcmds [7] = '{8'h08, 8'h09, 8'h0A, 8'h0B, 8'h0F, 8'h10, 8'h3F};
      logic [7:0] bcmds [5] = '{8'h20, 8'h21, 8'h22, 8'h23, 8'h3C};
      void'($urandom(32'd20240611));
      for (int i = 0; i < 6; i++) tel[i] = 16'(16'h1000 * (i + 1) + 16'h0A5 + i);
      repeat (10) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      // R9 reset state
      chk(!sda_oe, "R9 sda_oe after reset", sda_oe, 0);
      chk(cutoff_o == CRST, "R9 cutoff after reset", cutoff_o, CRST);

      // R1 foreign address
      m_start(); wbyte(8'h30, a);
      chk(!a, "R1 foreign address nack", a, 0);
      wbyte(8'h08, a);
      chk(!a && !sda_oe, "R1 silent after foreign address", a, 0);
      m_stop();

      // R10 read address without a command
      m_start(); wbyte(8'h17, a);
      chk(!a, "R10 read without command nack", a, 0);
      m_stop();

      // R2 every word command
      for (int i = 0; i < 7; i++) rd_word_chk(wcmds[i]);

      // R3 every string, full length, plus an early stop
      for (int i = 0; i < 5; i++) rd_block_chk(bcmds[i], 20);
      rd_block_chk(8'h20, 3);

      // R4 unknown commands
      m_start(); wbyte(8'h16, a); wbyte(8'h55, a);
      chk(!a, "R4 unknown 0x55 nack", a, 0);
      m_stop();

      // R5 threshold write and readback
      wr_word(8'h3F, 16'hBEEF, wa);
      chk(wa == 4'hF, "R5 write acks", wa, 15);
      repeat (4) @(negedge clk);
      cut_model = 16'hBEEF;
      chk(cutoff_o == 16'hBEEF, "R5 cutoff updated", cutoff_o, 16'hBEEF);
      rd_word_chk(8'h3F);

      // R8 write cut off after the low byte
      m_start(); wbyte(8'h16, a); wbyte(8'h3F, a); wbyte(8'h12, a); m_stop();
      repeat (4) @(negedge clk);
      chk(cutoff_o == cut_model, "R8 partial write ignored", cutoff_o, cut_model);
      chk(!sda_oe, "R8 released after stop", sda_oe, 0);

      // R6 write to read-only word
      wr_word(8'h09, 16'h1234, wa);
      chk(wa == 4'b0011, "R6 first data byte nack", wa, 3);
      chk(cutoff_o == cut_model, "R6 cutoff unchanged", cutoff_o, cut_model);
      rd_word_chk(8'h09);

      // random mix
      for (int it = 0; it < 30; it++) begin
         case ($urandom % 4)
            0: begin
               for (int i = 0; i < 6; i++) tel[i] = 16'($urandom);
               rd_word_chk(wcmds[$urandom % 7]);
            end
            1: begin
               c = wcmds[$urandom % 7]; v = 16'($urandom);
               wr_word(c, v, wa);
               repeat (4) @(negedge clk);
               if (c == 8'h3F) begin
                  cut_model = v;
                  chk(wa == 4'hF, "R5 random write acks", wa, 15);
               end else begin
                  chk(wa == 4'b0011, "R6 random read-only write", wa, 3);
               end
               chk(cutoff_o == cut_model, "R5 random cutoff", cutoff_o, cut_model);
            end
            2: rd_block_chk(bcmds[$urandom % 5], 20);
            default: begin
               do c = 8'($urandom); while (word_slot(c) >= 0 || str_idx(c) >= 0);
               m_start(); wbyte(8'h16, a); wbyte(c, a);
               chk(!a, $sformatf("R4 unknown %02h", c), a, 0);
               m_stop();
            end
         endcase
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule